// File: doc/BRIEF.md
# Serial Link Test Pattern Source

This block sits in front of the framing and line-coding stages of a serial sample link. Each clock it gives one 16-bit word to the downstream encoder. That word is either the live converter sample or one of three built-in test patterns: a fixed alternating 10-bit code group, or one of two pseudo-random bit sequences. A two-bit select input picks the source. A sync request takes precedence over every setting and sends the comma control character instead.

The word is registered. It appears one clock after the cycle in which `valid_i` is high. Two side flags tell the encoder what the word holds. `raw10_o` marks a pre-coded 10-bit group that must bypass the encoder. `ctrl_o` marks control characters. Each pseudo-random generator is a Fibonacci shift register seeded with all ones. It produces 16 bits per accepted word, and the first generated bit lands in the word MSB. Framing, 8b/10b coding and serialization are outside this block.

Top module: `tp_source`

## Requirements
- R1: While `rst_ni` is low, `word_o`, `valid_o`, `raw10_o` and `ctrl_o` are all zero.
- R2: When `valid_i` is high, `sync_req_i` is low and `pat_sel_i` is 2'b00, the next cycle shows `word_o` equal to `adc_data_i` with `raw10_o` and `ctrl_o` low.
- R3: When `valid_i` is high, `sync_req_i` is low and `pat_sel_i` is 2'b01, the next cycle shows `word_o` = 16'h02AA (the 10-bit group 1010101010 in bits 9:0, zeros above) with `raw10_o` high and `ctrl_o` low.
- R4: With select 2'b10, each accepted word holds the next 16 bits of the sequence 1 + x^9 + x^11, MSB first. Each bit is s[10] XOR s[8] of an 11-bit register s, and that bit is then shifted into s[0].
- R5: With select 2'b11, each accepted word holds the next 16 bits of the sequence 1 + x^14 + x^15, MSB first. Each bit is s[14] XOR s[13] of a 15-bit register s, and that bit is then shifted into s[0]. Both pattern modes keep `raw10_o` and `ctrl_o` low.
- R6: Both generators start from all ones after reset. On an accepted non-sync word whose select differs from the select of the last accepted non-sync word, the selected generator restarts from all ones.
- R7: When `valid_i` and `sync_req_i` are both high, the next cycle shows `word_o` = 16'hBCBC (two K28.5 bytes) with `ctrl_o` high and `raw10_o` low, whatever the select. Sync words neither advance the generators nor update the remembered select.
- R8: When `valid_i` is low, the next cycle shows `valid_o` low with `word_o` and both flags unchanged, and no generator advances. Otherwise `valid_o` follows `valid_i` one cycle later.
- R9: Neither generator state ever becomes all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| adc_data_i | input | 16 | Live converter sample |
| valid_i | input | 1 | Word strobe; one output word per high cycle |
| pat_sel_i | input | 2 | Source select: 00 data, 01 fixed group, 10 short PRBS, 11 long PRBS |
| sync_req_i | input | 1 | Sync request; forces the comma |
| word_o | output | 16 | Registered output word |
| valid_o | output | 1 | Word strobe, one cycle after valid_i |
| raw10_o | output | 1 | Word carries a pre-coded 10-bit group |
| ctrl_o | output | 1 | Word carries control characters |

## Verification
The bench targets select changes in the middle of a sequence and a return to a pattern after a sync burst. A design that reseeds on the wrong event would drift off the model sequence at exactly those words. Idle cycles placed between pattern words catch a generator that advances without a strobe, because every later word would then come out shifted by 16 bits. Sync with each select value checks the priority and the flags, and a design that let the select win would emit pattern data with `ctrl_o` low. The first words after reset compare the all-ones seed, and a wrong bit order or tap shows up as an early mismatch.

// File: rtl/tp_pkg.sv
package tp_pkg;
  localparam int unsigned WORD_W = 16;

  typedef enum logic [1:0] {
    MODE_DATA = 2'b00,
    MODE_D215 = 2'b01,
    MODE_P11  = 2'b10,
    MODE_P15  = 2'b11
  } tp_mode_e;

  localparam logic [WORD_W-1:0] COMMA_WORD = 16'hBCBC;
  localparam logic [9:0]        D215_GROUP = 10'b1010101010;
  localparam logic [WORD_W-1:0] D215_WORD  = {{(WORD_W-10){1'b0}}, D215_GROUP};
endpackage

// File: rtl/tp_prbs_gen.sv
module tp_prbs_gen #(
  parameter int unsigned WIDTH  = 11,
  parameter int unsigned TAP    = 9,
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic              restart_i,
  output logic [WORD_W-1:0] word_o
);
  localparam logic [WIDTH-1:0] SEED = '1;

  logic [WIDTH-1:0] state_q, start, next;

  assign start = restart_i ? SEED : state_q;

  always_comb begin
    logic [WIDTH-1:0] st;
    logic             fb;
    st     = start;
    word_o = '0;
    for (int i = 0; i < int'(WORD_W); i++) begin
      fb                   = st[WIDTH-1] ^ st[TAP-1];
      word_o[WORD_W-1-i]   = fb;
      st                   = {st[WIDTH-2:0], fb};
    end
    next = st;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    state_q <= SEED;
    else if (adv_i) state_q <= next;
  end

  assert_state_nonzero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0);
  assert_hold_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(state_q));
  assert_restart_seed_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && restart_i) |=> state_q == next_from_seed());

  function automatic logic [WIDTH-1:0] next_from_seed();
    logic [WIDTH-1:0] s;
    s = SEED;
    for (int i = 0; i < int'(WORD_W); i++) s = {s[WIDTH-2:0], s[WIDTH-1] ^ s[TAP-1]};
    return s;
  endfunction
endmodule

// File: rtl/tp_out_reg.sv
module tp_out_reg #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic [WORD_W-1:0] word_d_i,
  input  logic              raw10_d_i,
  input  logic              ctrl_d_i,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o,
  output logic              raw10_o,
  output logic              ctrl_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_o  <= '0;
      valid_o <= 1'b0;
      raw10_o <= 1'b0;
      ctrl_o  <= 1'b0;
    end else begin
      valid_o <= ld_i;
      if (ld_i) begin
        word_o  <= word_d_i;
        raw10_o <= raw10_d_i;
        ctrl_o  <= ctrl_d_i;
      end
    end
  end

  assert_idle_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_i |=> !valid_o && $stable(word_o) && $stable(raw10_o) && $stable(ctrl_o));
  assert_flags_exclusive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(raw10_o && ctrl_o));
endmodule

// File: rtl/tp_source.sv
module tp_source
  import tp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] adc_data_i,
  input  logic              valid_i,
  input  logic [1:0]        pat_sel_i,
  input  logic              sync_req_i,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o,
  output logic              raw10_o,
  output logic              ctrl_o
);
  tp_mode_e          mode, sel_q;
  logic              take, restart;
  logic [WORD_W-1:0] p11_word, p15_word, word_d;
  logic              raw10_d, ctrl_d;

  assign mode    = tp_mode_e'(pat_sel_i);
  assign take    = valid_i && !sync_req_i;
  assign restart = (mode != sel_q);

  // remembered select only tracks non-sync words
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sel_q <= MODE_DATA;
    else if (take) sel_q <= mode;
  end

  tp_prbs_gen #(.WIDTH(11), .TAP(9), .WORD_W(WORD_W)) u_p11 (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .adv_i     (take && mode == MODE_P11),
    .restart_i (restart),
    .word_o    (p11_word)
  );

  tp_prbs_gen #(.WIDTH(15), .TAP(14), .WORD_W(WORD_W)) u_p15 (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .adv_i     (take && mode == MODE_P15),
    .restart_i (restart),
    .word_o    (p15_word)
  );

  always_comb begin
    raw10_d = 1'b0;
    ctrl_d  = 1'b0;
    if (sync_req_i) begin
      word_d = COMMA_WORD;
      ctrl_d = 1'b1;
    end else begin
      unique case (mode)
        MODE_DATA: word_d = adc_data_i;
        MODE_D215: begin word_d = D215_WORD; raw10_d = 1'b1; end
        MODE_P11:  word_d = p11_word;
        default:   word_d = p15_word;
      endcase
    end
  end

  tp_out_reg #(.WORD_W(WORD_W)) u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ld_i      (valid_i),
    .word_d_i  (word_d),
    .raw10_d_i (raw10_d),
    .ctrl_d_i  (ctrl_d),
    .word_o    (word_o),
    .valid_o   (valid_o),
    .raw10_o   (raw10_o),
    .ctrl_o    (ctrl_o)
  );

  assert_sync_comma_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sync_req_i) |=> ctrl_o && !raw10_o && word_o == COMMA_WORD);
  assert_data_pass_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && mode == MODE_DATA) |=> word_o == $past(adc_data_i) && !ctrl_o && !raw10_o);
  assert_d215_word_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && mode == MODE_D215) |=> raw10_o && word_o[9:0] == D215_GROUP);
  assert_valid_follow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
endmodule

// File: tb/tp_source_tb.sv
`timescale 1ns/1ps
module tp_source_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] adc = '0;
  logic        vld = 1'b0;
  logic [1:0]  sel = 2'b00;
  logic        syn = 1'b0;
  logic [15:0] word;
  logic        vout, raw10, ctrl;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tp_source dut_i (
    .clk_i(clk), .rst_ni(rst_n), .adc_data_i(adc), .valid_i(vld),
    .pat_sel_i(sel), .sync_req_i(syn), .word_o(word), .valid_o(vout),
    .raw10_o(raw10), .ctrl_o(ctrl)
  );

  // model
  logic [14:0] m11, m15;
  logic [1:0]  msel;
  logic [15:0] e_word;
  logic        e_vld, e_raw, e_ctrl;
  string       e_req;

  function automatic logic [15:0] prbs(input logic [14:0] s, input int n, input int t,
                                       output logic [14:0] ns);
    logic [15:0] w = '0;
    logic [14:0] mask = (15'h1 << n) - 15'h1;
    for (int i = 0; i < 16; i++) begin
      logic fb = s[n-1] ^ s[t-1];
      w = {w[14:0], fb};
      s = ((s << 1) | {14'b0, fb}) & mask;
    end
    ns = s;
    return w;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model(input logic v, input logic [1:0] s, input logic sy, input logic [15:0] a);
    logic [14:0] ns;
    e_vld = v;
    if (!v) begin e_req = "R8"; return; end
    if (sy) begin
      e_word = 16'hBCBC; e_ctrl = 1; e_raw = 0; e_req = "R7";
      return;
    end
    if (s != msel) begin
      if (s == 2'b10) m11 = 15'h07FF;
      if (s == 2'b11) m15 = 15'h7FFF;
      e_req = "R6";
    end else e_req = "";
    msel = s; e_ctrl = 0; e_raw = 0;
    case (s)
      2'b00: begin e_word = a; e_req = {e_req, " R2"}; end
      2'b01: begin e_word = 16'h02AA; e_raw = 1; e_req = {e_req, " R3"}; end
      2'b10: begin e_word = prbs(m11, 11, 9, ns); m11 = ns; e_req = {e_req, " R4"}; end
      default: begin e_word = prbs(m15, 15, 14, ns); m15 = ns; e_req = {e_req, " R5"}; end
    endcase
  endtask

  task automatic compare();
    chk(vout == e_vld, {e_req, " R8"}, "valid", 32'(vout), 32'(e_vld));
    chk(word == e_word, e_req, "word", 32'(word), 32'(e_word));
    chk(raw10 == e_raw, e_req, "raw10", 32'(raw10), 32'(e_raw));
    chk(ctrl == e_ctrl, e_req, "ctrl", 32'(ctrl), 32'(e_ctrl));
  endtask

  // drive at negedge, check effect at following negedge
  task automatic step(input logic v, input logic [1:0] s, input logic sy, input logic [15:0] a);
    vld = v; sel = s; syn = sy; adc = a;
    model(v, s, sy, a);
    @(negedge clk);
    compare();
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    m11 = 15'h07FF; m15 = 15'h7FFF; msel = 2'b00;
    e_word = '0; e_vld = 0; e_raw = 0; e_ctrl = 0; e_req = "R1";
    repeat (3) @(negedge clk);
    chk(word == 0 && !vout && !raw10 && !ctrl, "R1", "reset outputs",
        {word, 13'b0, vout, raw10, ctrl}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // directed: seeds, idle gaps, sync mid-pattern, reseed on change
    step(1, 2'b00, 0, 16'hA5C3);
    step(1, 2'b10, 0, 0); step(1, 2'b10, 0, 0); step(0, 2'b10, 0, 0); step(1, 2'b10, 0, 0);
    step(1, 2'b11, 0, 0); step(1, 2'b11, 0, 0);
    step(1, 2'b11, 1, 0); step(1, 2'b00, 1, 0); step(1, 2'b01, 1, 0);
    step(1, 2'b11, 0, 0); step(0, 2'b11, 0, 0); step(1, 2'b11, 0, 0);
    step(1, 2'b01, 0, 0); step(0, 2'b00, 0, 16'h1234);
    step(1, 2'b10, 0, 0); step(1, 2'b11, 0, 0); step(1, 2'b10, 0, 0);
    step(1, 2'b00, 0, 16'hFFFF); step(1, 2'b00, 0, 16'h0000);
    // random
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] s = sel;
      if ($urandom_range(0, 15) == 0) s = 2'($urandom);
      step($urandom_range(0, 9) != 0, s, $urandom_range(0, 11) == 0, 16'($urandom));
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule